// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block holds an eight-bit word that can be captured from a parallel input bus and then moved out one bit at a time on a serial output. A low level on the shift/load control copies the parallel bus into the register continuously, whatever the device clock is doing. When the control is high, each rising edge of the device clock moves the word one stage toward the output stage, and the serial input fills the far stage. A hold input, when high, freezes the contents against device-clock edges. Both a true and an inverted copy of the output stage are driven.

The block runs on a system clock. The shift/load control, the device clock and the hold input are passed through a synchroniser of `SYNC_STAGES` flops. Rising edges of the device clock are then found by comparing the synchronised level with its previous value. The hold input may change only while the device clock is high, so that releasing it cannot create a false edge. A generate option, `REG_OUT`, adds one output flop after the output stage.

Top module: `plso_shifter`

## Requirements
- R1: While `rst_n` is low the register is all zeros, so `q_out` is 0 and `q_out_n` is 1.
- R2: While `load_n` is low the register follows `par_in` continuously, and changes on `par_in` are tracked as well. `par_in[0]` (the first bit shifted out) goes to the output stage 0, and `par_in[7]` goes to the far stage 7.
- R3: While `load_n` is low, rising edges of `dev_clk` do not shift the register.
- R4: With `load_n` high and `clk_hold` low, each rising edge of `dev_clk` moves stage i+1 into stage i, and `ser_in` enters stage 7.
- R5: With `clk_hold` high, rising edges of `dev_clk` leave the contents unchanged.
- R6: `q_out` shows stage 0 and `q_out_n` is always its inverse.
- R7: Changes on `ser_in` with no qualifying rising edge leave the contents and the outputs unchanged.
- R8: Falling edges of `dev_clk` never shift the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock that samples all control inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_in | input | WIDTH | Parallel word; bit 0 is shifted out first |
| ser_in | input | 1 | Serial fill bit for the far stage |
| load_n | input | 1 | Low: load from par_in; high: shift mode |
| dev_clk | input | 1 | Device clock; its rising edges shift |
| clk_hold | input | 1 | High: ignore device-clock edges |
| q_out | output | 1 | Output stage value |
| q_out_n | output | 1 | Inverse of q_out |

## Verification
A change on `load_n` or a rising edge on `dev_clk` takes effect on the outputs SYNC_STAGES + 1 + REG_OUT system-clock edges after the input moves. With the defaults this is three edges. The bench drives inputs at the falling system-clock edge and waits six full cycles before it samples any output, so every result is settled and no check depends on the exact edge. Each device-clock half period also lasts six cycles, so the output is checked both after each rising edge and after each falling edge.

// File: rtl/plso_pkg.sv
package plso_pkg;

   // Operation chosen by the core for the current system-clock cycle
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_SHIFT = 2'd2
   } plso_op_e;

   // Positions of the control bits inside the synchroniser vector
   localparam int unsigned CTL_LOAD = 0;
   localparam int unsigned CTL_HOLD = 1;
   localparam int unsigned CTL_CLK  = 2;
   localparam int unsigned CTL_W    = 3;

endpackage

// File: rtl/plso_sync.sv
module plso_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("plso_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("plso_sync: WIDTH must be at least 1");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= {STAGES{RST_VAL[gi]}};
            end else begin
               chain <= {chain[STAGES-2:0], d[gi]};
            end
         end
         assign q[gi] = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/plso_edge.sv
module plso_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise
);

   logic prev;

   // Reset to 1 so that a clock already high at reset release gives no edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= 1'b1;
      end else begin
         prev <= level;
      end
   end

   assign rise = level & ~prev;

   // R4: one device-clock edge gives a single-cycle shift request
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/plso_core.sv
module plso_core
   import plso_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   input  logic             load_s_n,
   input  logic             hold_s,
   input  logic             rise,
   output logic [WIDTH-1:0] stages
);

   localparam int unsigned TOP = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("plso_core: WIDTH must be at least 2");
      end
   endgenerate

   plso_op_e         op;
   logic [WIDTH-1:0] shifted;

   // Load wins over everything; an inhibited or absent edge leaves contents alone
   always_comb begin
      if (!load_s_n) begin
         op = OP_LOAD;
      end else if (rise && !hold_s) begin
         op = OP_SHIFT;
      end else begin
         op = OP_IDLE;
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < TOP; gi++) begin : g_move
         assign shifted[gi] = stages[gi+1];
      end
   endgenerate
   assign shifted[TOP] = ser_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stages <= '0;
      end else begin
         unique case (op)
            OP_LOAD:  stages <= par_in;
            OP_SHIFT: stages <= shifted;
            default:  stages <= stages;
         endcase
      end
   end

   // R2: low control captures the bus
   a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
      !load_s_n |=> stages == $past(par_in));

   // R3: an edge during load does not shift
   a_r3_load_beats_clock: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_s_n && rise) |=> stages == $past(par_in));

   // R4: qualified edge moves every bit one place toward stage 0
   a_r4_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
      (load_s_n && rise && !hold_s) |=>
         stages == {$past(ser_in), $past(stages[TOP:1])});

   // R5: inhibit freezes the contents
   a_r5_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (load_s_n && hold_s) |=> $stable(stages));

   // R7, R8: no rising edge in shift mode means no change
   a_r7_no_edge_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (load_s_n && !rise) |=> $stable(stages));

endmodule

// File: rtl/plso_shifter.sv
module plso_shifter
   import plso_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          REG_OUT     = 1'b0
) (
   input  logic             sys_clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   input  logic             load_n,
   input  logic             dev_clk,
   input  logic             clk_hold,
   output logic             q_out,
   output logic             q_out_n
);

   logic [CTL_W-1:0] ctl_raw;
   logic [CTL_W-1:0] ctl_s;
   logic             rise;
   logic [WIDTH-1:0] stages;
   logic             out_bit;

   assign ctl_raw[CTL_LOAD] = load_n;
   assign ctl_raw[CTL_HOLD] = clk_hold;
   assign ctl_raw[CTL_CLK]  = dev_clk;

   // All controls reset high: shift mode, held, clock high (no false edge)
   plso_sync #(
      .WIDTH   (CTL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({CTL_W{1'b1}})
   ) u_sync (
      .clk   (sys_clk),
      .rst_n (rst_n),
      .d     (ctl_raw),
      .q     (ctl_s)
   );

   plso_edge u_edge (
      .clk   (sys_clk),
      .rst_n (rst_n),
      .level (ctl_s[CTL_CLK]),
      .rise  (rise)
   );

   plso_core #(
      .WIDTH (WIDTH)
   ) u_core (
      .clk      (sys_clk),
      .rst_n    (rst_n),
      .par_in   (par_in),
      .ser_in   (ser_in),
      .load_s_n (ctl_s[CTL_LOAD]),
      .hold_s   (ctl_s[CTL_HOLD]),
      .rise     (rise),
      .stages   (stages)
   );

   generate
      if (REG_OUT) begin : g_reg_out
         logic q_r;
         always_ff @(posedge sys_clk or negedge rst_n) begin
            if (!rst_n) begin
               q_r <= 1'b0;
            end else begin
               q_r <= stages[0];
            end
         end
         assign out_bit = q_r;
      end else begin : g_comb_out
         assign out_bit = stages[0];
      end
   endgenerate

   assign q_out   = out_bit;
   assign q_out_n = ~out_bit;

   // R1: reset leaves the output stage clear
   a_r1_reset_clear: assert property (@(posedge sys_clk)
      !rst_n |-> (q_out == 1'b0));

endmodule

// File: tb/test_plso_shifter.sv
module test_plso_shifter;

   localparam int unsigned W = 8;

   logic         sys_clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] par_in = '0;
   logic         ser_in = 1'b0;
   logic         load_n = 1'b1;
   logic         dev_clk = 1'b0;
   logic         clk_hold = 1'b0;
   logic         q_out;
   logic         q_out_n;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #5 sys_clk = ~sys_clk;

   plso_shifter #(.WIDTH(W)) i_plso_shifter (
      .sys_clk  (sys_clk),
      .rst_n    (rst_n),
      .par_in   (par_in),
      .ser_in   (ser_in),
      .load_n   (load_n),
      .dev_clk  (dev_clk),
      .clk_hold (clk_hold),
      .q_out    (q_out),
      .q_out_n  (q_out_n)
   );

   task automatic settle();
      repeat (6) @(negedge sys_clk);
   endtask

   task automatic check(string tag, logic got, logic exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: q_out=%b expected %b", tag, got, exp);
      end
      n_checks++;
      if (q_out_n !== ~got) begin
         n_fails++;
         $display("FAIL R6 (%s): q_out_n=%b expected %b", tag, q_out_n, ~got);
      end
   endtask

   task automatic clk_rise();
      dev_clk = 1'b1;
      settle();
   endtask

   task automatic clk_fall();
      dev_clk = 1'b0;
      settle();
   endtask

   task automatic load_word(logic [W-1:0] w);
      par_in = w;
      load_n = 1'b0;
      settle();
      load_n = 1'b1;
      settle();
   endtask

   // R1: reset state
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge sys_clk);
      check("R1 in reset", q_out, 1'b0);
      rst_n = 1'b1;
      settle();
      check("R1 after reset", q_out, 1'b0);
   endtask

   // R2, R4, R6, R8: load then shift eight times with ser_in high
   task automatic t_shift_out(logic [W-1:0] w);
      load_word(w);
      check("R2 first bit after load", q_out, w[0]);
      ser_in = 1'b1;
      for (int k = 1; k <= 8; k++) begin
         clk_rise();
         check($sformatf("R4 shift %0d", k), q_out, (k < 8) ? w[k] : 1'b1);
         clk_fall();
         check($sformatf("R8 falling %0d", k), q_out, (k < 8) ? w[k] : 1'b1);
      end
      clk_rise();
      check("R4 serial fill reaches output", q_out, 1'b1);
      clk_fall();
   endtask

   // R2, R3: edges while loading do nothing, bus is tracked
   task automatic t_load_priority();
      par_in = 8'h01;
      ser_in = 1'b0;
      load_n = 1'b0;
      settle();
      check("R2 load follows bus", q_out, 1'b1);
      for (int k = 0; k < 3; k++) begin
         clk_rise();
         check("R3 edge during load", q_out, 1'b1);
         clk_fall();
      end
      par_in = 8'h00;
      settle();
      check("R2 bus change tracked while low", q_out, 1'b0);
      par_in = 8'h01;
      settle();
      load_n = 1'b1;
      settle();
      check("R2 value kept after release", q_out, 1'b1);
   endtask

   // R5: inhibit freezes, release while clock is high
   task automatic t_inhibit();
      logic [W-1:0] w = 8'h5A;
      load_word(w);
      ser_in = 1'b0;
      clk_rise(); clk_fall();
      clk_rise(); clk_fall();
      check("R4 two shifts", q_out, w[2]);
      clk_rise();
      check("R4 third shift", q_out, w[3]);
      clk_hold = 1'b1;
      settle();
      clk_fall();
      for (int k = 0; k < 3; k++) begin
         clk_rise();
         check("R5 inhibited edge", q_out, w[3]);
         clk_fall();
      end
      clk_rise();
      clk_hold = 1'b0;
      settle();
      check("R5 release while high", q_out, w[3]);
      clk_fall();
      clk_rise();
      check("R5 shifting resumes", q_out, w[4]);
      clk_fall();
      clk_rise();
      check("R5 shifting resumes 2", q_out, w[5]);
      clk_fall();
   endtask

   // R7: ser_in wiggles without edges are not captured
   task automatic t_serial_quiet();
      ser_in = 1'b0;
      load_word(8'h00);
      for (int k = 0; k < 4; k++) begin
         ser_in = ~ser_in;
         settle();
         check("R7 ser_in toggle", q_out, 1'b0);
      end
      ser_in = 1'b0;
      settle();
      for (int k = 1; k <= 8; k++) begin
         clk_rise();
         check($sformatf("R7 no stray bit, shift %0d", k), q_out, 1'b0);
         clk_fall();
      end
   endtask

   initial begin
      t_reset();
      t_shift_out(8'hB4);
      t_shift_out(8'h3C);
      t_load_priority();
      t_inhibit();
      t_serial_quiet();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge sys_clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule